// File: doc/BRIEF.md
# Card Clock and Operation Control Unit

This unit drives the card clock of an SD/MMC host and turns one-shot control writes into clean clock gating, operation launches and a timed soft reset. The block runs from `clk_i`, which is twice the module clock rate. It produces `card_clk_o` as a registered square wave whose half period is 2^div cycles of `clk_i`. The card clock is therefore the module clock shifted right by the 3-bit divider, from module rate down to 1/128 of it.

Software writes a control word with separate strobe bits. The strobes are not stored: each acts once, at the edge that takes the write. The status word reports what the hardware is doing. It shows the clock-running flag, which drops only once the card clock is really parked low. It shows the reset-busy flag, which clears by itself after a fixed count. It also shows whether a launched operation is still outstanding. A launch shows up as a one-cycle `op_go_o` pulse to the command sequencer, and the sequencer answers with `op_done_i`.

All pins are plain control and status signals. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure.

Top module: `ccu_top`

## Requirements
- R1: Address 0 is the control word on write and the status word on read. Address 1 holds the divider in bits [2:0]. Status bit 15 is reset-busy, bit 8 is clock-running and bit 4 is operation-active. After `rst_ni` the status reads 0, the divider reads 0, and `card_clk_o` and `op_go_o` are 0.
- R2: For every divider value d from 0 to 7, a running card clock stays high for exactly 2^d cycles of `clk_i` and low for exactly 2^d cycles.
- R3: Control bit 1 (start) sets status bit 8 at the edge that takes the write. The card clock rises at the following edge.
- R4: A divider write does not change the card-clock phase in progress. The new value takes effect from the next card-clock edge.
- R5: Control bit 0 (stop) written while the card clock is high lets the high phase finish. The card clock then falls and status bit 8 drops at that same edge, and the clock stays low.
- R6: A stop written while the card clock is low drops status bit 8 at the edge that takes the write, and no further rising edge follows.
- R7: When stop and start are set in the same write, stop wins, and a stopped clock stays stopped.
- R8: Control bit 2 (go), written with start or while the clock runs, gives a one-cycle `op_go_o` pulse. It also sets status bit 4, which stays set until `op_done_i` is sampled high.
- R9: A go write is ignored, with no pulse and no change to bit 4, when the clock is stopped and start is not set, or while an operation is active.
- R10: Control bit 3 (soft reset) takes priority over the other bits of the same write. It holds status bit 15 high for exactly RST_CYCLES cycles. It clears the divider, the clock-running flag and the operation-active flag, and it forces `card_clk_o` low. All writes that arrive while bit 15 is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock, twice the module clock rate |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | ADDR_W | Write address |
| wr_data_i | input | DATA_W | Write data |
| rd_addr_i | input | ADDR_W | Read address |
| rd_data_o | output | DATA_W | Read data, combinational |
| op_done_i | input | 1 | Sequencer reports that the launched operation has finished |
| op_go_o | output | 1 | One-cycle operation launch pulse |
| card_clk_o | output | 1 | Card clock |

## Verification
The bench uses the default parameters: a 3-bit divider and an 8-cycle soft reset. The divider width keeps the longest half period at 128 cycles, so the bench can sweep all eight divider settings and count both phases of each one directly. The short reset makes it practical to count the busy window exactly and to try writes inside it. Stop and divider writes are placed at chosen sample points within a phase, so that phase boundaries and flag timing can be compared against cycle counts worked out in the bench.

// File: rtl/ccu_pkg.sv
package ccu_pkg;
  // control word strobe positions
  localparam int CtlStop  = 0;
  localparam int CtlStart = 1;
  localparam int CtlGo    = 2;
  localparam int CtlSrst  = 3;
  // status word flag positions
  localparam int StOpAct  = 4;
  localparam int StRun    = 8;
  localparam int StRst    = 15;

  typedef struct packed {
    logic srst;
    logic go;
    logic start;
    logic stop;
  } ccu_cmd_t;
endpackage

// File: rtl/ccu_rst_seq.sv
module ccu_rst_seq #(
  parameter int RST_CYCLES = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic trig_i,
  output logic busy_o
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (trig_i)          cnt_q <= CW'(RST_CYCLES);
    else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
  end

  assign busy_o = (cnt_q != '0);

  AST_RST_BOUNDED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !trig_i) |=> (cnt_q < $past(cnt_q))); // R10
endmodule

// File: rtl/ccu_clkgen.sv
module ccu_clkgen #(
  parameter int DIV_W = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             card_clk_o,
  output logic             running_o,
  output logic [DIV_W-1:0] act_div_o
);
  localparam int CNT_W = (1 << DIV_W) - 1;

  logic [CNT_W-1:0] cnt_q;
  logic             pend_q, pend_d, stop_req;

  function automatic logic [CNT_W-1:0] half_len(input logic [DIV_W-1:0] d);
    logic [CNT_W:0] one;
    one = {{CNT_W{1'b0}}, 1'b1};
    return CNT_W'((one << d) - 1'b1);
  endfunction

  assign stop_req = stop_i | pend_q;

  always_comb begin
    pend_d = pend_q;
    if (start_i && !stop_i) pend_d = 1'b0;
    else if (stop_i)        pend_d = 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0; pend_q <= 1'b0; card_clk_o <= 1'b0;
      running_o <= 1'b0; act_div_o <= '0;
    end else if (clr_i) begin
      cnt_q <= '0; pend_q <= 1'b0; card_clk_o <= 1'b0;
      running_o <= 1'b0; act_div_o <= '0;
    end else if (!running_o) begin
      pend_q <= 1'b0;
      cnt_q  <= '0;
      if (start_i && !stop_i) running_o <= 1'b1;
    end else if (stop_req && !card_clk_o) begin
      running_o <= 1'b0; pend_q <= 1'b0; cnt_q <= '0;
    end else if (cnt_q == '0) begin
      if (card_clk_o && stop_req) begin
        card_clk_o <= 1'b0; running_o <= 1'b0; pend_q <= 1'b0;
      end else begin
        card_clk_o <= ~card_clk_o;
        act_div_o  <= div_i;
        cnt_q      <= half_len(div_i);
        pend_q     <= pend_d;
      end
    end else begin
      cnt_q  <= cnt_q - 1'b1;
      pend_q <= pend_d;
    end
  end

  AST_IDLE_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !running_o |-> !card_clk_o); // R5
  AST_PEND_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_q |-> (running_o && card_clk_o)); // R5
  AST_DIV_AT_EDGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && $stable(card_clk_o)) |-> $stable(act_div_o)); // R4
endmodule

// File: rtl/ccu_opctl.sv
module ccu_opctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic go_req_i,
  input  logic op_done_i,
  output logic op_go_o,
  output logic op_act_o
);
  logic launch;
  assign launch = go_req_i && !op_act_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      op_go_o <= 1'b0; op_act_o <= 1'b0;
    end else if (clr_i) begin
      op_go_o <= 1'b0; op_act_o <= 1'b0;
    end else begin
      op_go_o <= launch;
      if (launch)         op_act_o <= 1'b1;
      else if (op_done_i) op_act_o <= 1'b0;
    end
  end

  AST_GO_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_go_o |=> !op_go_o); // R8
  AST_ACT_FROM_GO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(op_act_o) |-> op_go_o); // R8
endmodule

// File: rtl/ccu_top.sv
module ccu_top #(
  parameter int ADDR_W     = 2,
  parameter int DATA_W     = 16,
  parameter int DIV_W      = 3,
  parameter int RST_CYCLES = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  input  logic              op_done_i,
  output logic              op_go_o,
  output logic              card_clk_o
);
  import ccu_pkg::*;

  localparam logic [ADDR_W-1:0] AddrCtl = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] AddrDiv = ADDR_W'(1);

  ccu_cmd_t         cmd;
  logic             rst_busy, clr, running, op_act, go_req;
  logic [DIV_W-1:0] div_q, act_div;
  logic             unused_wr;

  assign unused_wr = ^wr_data_i[DATA_W-1:4];

  // strobe decode: soft reset masks the rest, busy window masks everything
  always_comb begin
    cmd = '0;
    if (wr_en_i && wr_addr_i == AddrCtl && !rst_busy) begin
      cmd.srst = wr_data_i[CtlSrst];
      if (!wr_data_i[CtlSrst]) begin
        cmd.stop  = wr_data_i[CtlStop];
        cmd.start = wr_data_i[CtlStart];
        cmd.go    = wr_data_i[CtlGo];
      end
    end
  end

  assign clr    = cmd.srst | rst_busy;
  assign go_req = cmd.go && !cmd.stop && (cmd.start || running);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     div_q <= '0;
    else if (clr)    div_q <= '0;
    else if (wr_en_i && wr_addr_i == AddrDiv) div_q <= wr_data_i[DIV_W-1:0];
  end

  ccu_rst_seq #(.RST_CYCLES(RST_CYCLES)) i_rst (
    .clk_i(clk_i), .rst_ni(rst_ni), .trig_i(cmd.srst), .busy_o(rst_busy));

  ccu_clkgen #(.DIV_W(DIV_W)) i_clk (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .start_i(cmd.start),
    .stop_i(cmd.stop), .div_i(div_q), .card_clk_o(card_clk_o),
    .running_o(running), .act_div_o(act_div));

  ccu_opctl i_op (
    .clk_i(clk_i), .rst_ni(rst_ni), .clr_i(clr), .go_req_i(go_req),
    .op_done_i(op_done_i), .op_go_o(op_go_o), .op_act_o(op_act));

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == AddrCtl) begin
      rd_data_o[StRst]   = rst_busy;
      rd_data_o[StRun]   = running;
      rd_data_o[StOpAct] = op_act;
    end else if (rd_addr_i == AddrDiv) begin
      rd_data_o[DIV_W-1:0] = div_q;
    end
  end

  AST_RST_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_busy |-> (!running && !op_act && div_q == '0 && act_div == '0)); // R10
  AST_GO_NEEDS_CLK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_go_o |-> running); // R9
endmodule

// File: tb/test_ccu_top.sv
module test_ccu_top;
  logic        clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, op_done = 1'b0;
  logic [1:0]  wr_addr = '0, rd_addr = '0;
  logic [15:0] wr_data = '0, rd_data;
  logic        op_go, card_clk;
  int n_chk = 0, n_fail = 0;
  bit done = 0;
  localparam int RST_CYC = 8;

  always #5 clk = ~clk;

  ccu_top i_ccu_top (.clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data), .op_done_i(op_done),
    .op_go_o(op_go), .card_clk_o(card_clk));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 1'b0; wr_data = '0;
  endtask

  function automatic int st(input int b); return int'(rd_data[b]); endfunction

  task automatic rd_div(output int v);
    rd_addr = 2'd1; #1; v = int'(rd_data); rd_addr = 2'd0; #1;
  endtask

  task automatic wait_run_low();
    for (int k = 0; k < 400 && st(8) == 1; k++) @(negedge clk);
  endtask

  task automatic wait_rise();
    for (int k = 0; k < 400 && card_clk; k++) @(negedge clk);
    for (int k = 0; k < 400 && !card_clk; k++) @(negedge clk);
  endtask

  task automatic count_level(input logic lvl, output int n);
    n = 0;
    for (int k = 0; k < 400 && card_clk == lvl; k++) begin n++; @(negedge clk); end
  endtask

  task automatic never_rises(input int cyc, input string req);
    int hits = 0;
    for (int k = 0; k < cyc; k++) begin @(negedge clk); if (card_clk) hits++; end
    chk(hits == 0, req, hits, 0);
  endtask

  initial begin
    int v, hi, lo;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #1;
    // R1 reset state
    chk(rd_data == 16'h0, "R1 status", int'(rd_data), 0);
    rd_div(v); chk(v == 0, "R1 divider", v, 0);
    chk(!card_clk && !op_go, "R1 outputs", int'({card_clk, op_go}), 0);

    // R2 sweep every divider value
    for (int d = 0; d < 8; d++) begin
      wr(2'd0, 16'h1); wait_run_low();
      wr(2'd1, 16'(d));
      wr(2'd0, 16'h2);
      wait_rise(); count_level(1'b1, hi); count_level(1'b0, lo);
      chk(hi == (1 << d), "R2 high phase", hi, 1 << d);
      chk(lo == (1 << d), "R2 low phase", lo, 1 << d);
    end
    wr(2'd0, 16'h1); wait_run_low();

    // R3 start timing, R4 divider change mid-phase
    wr(2'd1, 16'd3);
    wr(2'd0, 16'h2);
    chk(st(8) == 1 && !card_clk, "R3 run set, clock still low", int'(card_clk), 0);
    @(negedge clk);
    chk(card_clk == 1'b1, "R3 rise next edge", int'(card_clk), 1);
    @(negedge clk);
    wr(2'd1, 16'd0);
    count_level(1'b1, hi); chk(hi == 5, "R4 old phase kept", hi, 5);
    count_level(1'b0, lo); chk(lo == 1, "R4 new low phase", lo, 1);
    count_level(1'b1, hi); chk(hi == 1, "R4 new high phase", hi, 1);

    // R5 stop while high (div 2 -> 4 high samples)
    wr(2'd1, 16'd2); wait_rise(); wait_rise();
    wr(2'd0, 16'h1);
    chk(st(8) == 1 && card_clk, "R5 high phase continues", st(8), 1);
    @(negedge clk);
    chk(st(8) == 1 && card_clk, "R5 still high", int'(card_clk), 1);
    @(negedge clk);
    chk(st(8) == 0 && !card_clk, "R5 fall with run drop", st(8), 0);
    never_rises(40, "R5 stays low");

    // R6 stop while low
    wr(2'd0, 16'h2); wait_rise();
    count_level(1'b1, hi);
    wr(2'd0, 16'h1);
    chk(st(8) == 0 && !card_clk, "R6 run drops in low phase", st(8), 0);
    never_rises(20, "R6 no further rise");

    // R7 stop and start together
    wr(2'd0, 16'h3);
    chk(st(8) == 0, "R7 stop wins", st(8), 0);
    never_rises(20, "R7 clock idle");

    // R8 go with start
    wr(2'd0, 16'h6);
    chk(op_go == 1'b1 && st(4) == 1, "R8 launch pulse", int'(op_go), 1);
    @(negedge clk);
    chk(op_go == 1'b0 && st(4) == 1, "R8 single pulse, active held", int'(op_go), 0);
    // R9 go while active
    wr(2'd0, 16'h4);
    chk(op_go == 1'b0 && st(4) == 1, "R9 go ignored while active", int'(op_go), 0);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    chk(st(4) == 0, "R8 done clears active", st(4), 0);
    wr(2'd0, 16'h4);
    chk(op_go == 1'b1, "R8 go while running", int'(op_go), 1);
    op_done = 1'b1; @(negedge clk); op_done = 1'b0;
    wr(2'd0, 16'h1); wait_run_low();
    wr(2'd0, 16'h4);
    chk(op_go == 1'b0 && st(4) == 0, "R9 go ignored when stopped", st(4), 0);

    // R10 soft reset with other bits, exact busy length
    wr(2'd1, 16'd5); wr(2'd0, 16'h6);
    wr(2'd0, 16'hF);
    chk(st(15) == 1 && st(8) == 0 && st(4) == 0 && !card_clk, "R10 reset clears flags",
        int'(rd_data), 16'h8000);
    chk(op_go == 1'b0, "R10 reset masks go", int'(op_go), 0);
    hi = 0;
    for (int k = 0; k < 100 && st(15) == 1; k++) begin hi++; @(negedge clk); #1; end
    chk(hi == RST_CYC, "R10 busy length", hi, RST_CYC);
    rd_div(v); chk(v == 0, "R10 divider cleared", v, 0);
    // R10 writes during busy ignored
    wr(2'd0, 16'h8);
    wr(2'd1, 16'd6);
    wr(2'd0, 16'h2);
    for (int k = 0; k < 100 && st(15) == 1; k++) @(negedge clk);
    #1; rd_div(v);
    chk(v == 0, "R10 divider write ignored", v, 0);
    chk(st(8) == 0, "R10 start ignored", st(8), 0);
    never_rises(10, "R10 clock held low");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #1500000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule